// File: doc/BRIEF.md
# Segmented Status-Word Trap Unit

This block is the privilege and address-translation core of a small processor. It holds the processor status word: a privilege mode (user or supervisor), a segment base, a segment length and a program counter. Loads and stores present a virtual address. The unit adds the segment base to form the physical address, but only if the virtual address lies within the segment length.

Four things cause a trap: an explicit trap request, a virtual address beyond the segment length, a privileged operation issued in user mode, and a return command issued in user mode. On a trap the unit writes the live status word into memory slot 0 and reads the handler's status word from memory slot 1. A supervisor return command reloads the status word from slot 0. Each field takes one memory beat. The new status word replaces the old one as a whole on the final beat. A trap request that arrives during a swap is held until the swap completes.

Top module: `psw_trap_unit`

## Requirements
- R1: After reset the unit is idle (`busy` low) in supervisor mode, with base 0, length SZ and program counter 0.
- R2: When idle, a request with virtual address `va` <= length gives `accessOk` high and `physAddr` = (base + va) modulo 2^AW.
- R3: A request with `va` > length gives `accessOk` low, and a trap starts in the next cycle.
- R4: A trap first writes slot 0 (word addresses 0..3), one field per cycle, in the order mode, base, length, program counter. The mode is written as 1 for supervisor and 0 for user.
- R5: A trap then reads words 4..7 in the same field order. The status outputs do not change while `busy` is high, and they take all four loaded values together once `busy` falls.
- R6: A return command in supervisor mode reads words 0..3 over four cycles, makes no memory write, and restores the status word from them.
- R7: A privileged operation in supervisor mode raises `privAccept` and starts no swap. In user mode it gives `privAccept` low and starts a trap.
- R8: A return command in user mode starts a trap, not a return.
- R9: A trap request raised while `busy` is high is remembered. After one idle cycle, the held trap starts a new trap sequence.
- R10: `busy` is high for exactly 8 cycles per trap and 4 cycles per return. `accessOk` is low and program-counter writes are ignored throughout.
- R11: Only bit 0 of a loaded mode word counts (1 = supervisor). The other bits are ignored.
- R12: While idle with no swap starting, `pcWrEn` loads `pcIn` into the program counter on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Explicit trap request |
| retReq | input | 1 | Return-from-trap command (privileged) |
| privOp | input | 1 | A privileged operation is being issued |
| pcWrEn | input | 1 | Program-counter update strobe |
| pcIn | input | AW | New program-counter value |
| memReq | input | 1 | Load/store address valid |
| memVa | input | AW | Virtual address of the load/store |
| physAddr | output | AW | Translated physical address |
| accessOk | output | 1 | Access permitted this cycle |
| privAccept | output | 1 | Privileged operation allowed to execute |
| busy | output | 1 | Status-word swap in progress |
| pswMode | output | 1 | Current mode, 1 = supervisor |
| pswBase | output | AW | Current segment base |
| pswLen | output | AW | Current segment length |
| pswPc | output | AW | Current program counter |
| memAddr | output | AW | Swap port word address |
| memWdata | output | AW | Swap port write data |
| memWe | output | 1 | Swap port write strobe |
| memRe | output | 1 | Swap port read strobe (data returned in the same cycle) |
| memRdata | input | AW | Swap port read data |

## Verification
The hardest case is a trap request that arrives while a swap is already running. Such a request must neither disturb the beats in flight nor be lost. The bench raises `trapReq` for a single cycle in the middle of a trap's read phase. It then checks that one idle cycle follows and that a second full save and load runs on the status word that was just loaded. To reach user mode with a chosen segment, the bench plants handler words in slot 1 before each trap. This lets the translation sweeps, the fault boundary at length+1, and the user-mode privileged and return cases all run on segments the bench itself defined.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_SUP  = 1'b1
  } mode_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       memWrite;  // write current field to slot 0
    logic       memRead;   // read field from selected slot
    logic       slot;      // slot index (0 or 1)
    logic [1:0] field;     // 0 mode, 1 base, 2 length, 3 pc
    logic       commit;    // last read beat: replace status word
    logic       pcAllow;   // external pc writes permitted
  } swapCtl_t;

endpackage

// File: rtl/psw_control.sv
module psw_control
  import psw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trapReq,
  input  logic     retReq,
  input  logic     privOp,
  input  logic     isUser,
  input  logic     addrFault,
  output swapCtl_t ctl,
  output logic     busy,
  output logic     privAccept
);

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_LOAD} state_e;

  state_e     state;
  logic [1:0] beat;
  logic       loadSlot;
  logic       pending;
  logic       idle;
  logic       trapNow;
  logic       retNow;

  always_comb begin
    idle    = (state == ST_IDLE);
    trapNow = idle && (trapReq || pending || (privOp && isUser) ||
                       (retReq && isUser) || addrFault);
    retNow  = idle && retReq && !isUser && !trapNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat     <= 2'd0;
      loadSlot <= 1'b0;
      pending  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trapNow) begin
            state   <= ST_SAVE;
            beat    <= 2'd0;
            pending <= 1'b0;
          end else if (retNow) begin
            state    <= ST_LOAD;
            loadSlot <= 1'b0;
            beat     <= 2'd0;
          end
        end
        ST_SAVE: begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            state    <= ST_LOAD;
            loadSlot <= 1'b1;
          end
        end
        ST_LOAD: begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (!idle && trapReq) pending <= 1'b1;
    end
  end

  always_comb begin
    ctl.memWrite = (state == ST_SAVE);
    ctl.memRead  = (state == ST_LOAD);
    ctl.slot     = (state == ST_LOAD) ? loadSlot : 1'b0;
    ctl.field    = beat;
    ctl.commit   = (state == ST_LOAD) && (beat == 2'd3);
    ctl.pcAllow  = idle && !trapNow && !retNow;
    busy         = !idle;
    privAccept   = idle && privOp && !isUser;
  end

  // R6: a supervisor return begins by reading slot 0, field 0
  assert_ret_reads_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retNow |=> (ctl.memRead && !ctl.memWrite && !ctl.slot && ctl.field == 2'd0));

  // R7: user privileged op starts a save sequence
  assert_user_priv_traps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && privOp && isUser) |=> (state == ST_SAVE && beat == 2'd0));

  // R9: a trap request during a swap is remembered
  assert_trap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trapReq) |=> pending);

  // R9: a held trap starts as soon as the unit is idle
  assert_held_trap_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pending) |=> (state == ST_SAVE));

endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int AW = 8,
  parameter int SZ = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  swapCtl_t      ctl,
  input  logic          pcWrEn,
  input  logic [AW-1:0] pcIn,
  input  logic          memReq,
  input  logic [AW-1:0] memVa,
  input  logic [AW-1:0] memRdata,
  output logic          isUser,
  output logic          addrFault,
  output logic          accessOk,
  output logic [AW-1:0] physAddr,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] memWdata,
  output logic          memWe,
  output logic          memRe,
  output logic          pswMode,
  output logic [AW-1:0] pswBase,
  output logic [AW-1:0] pswLen,
  output logic [AW-1:0] pswPc
);

  localparam logic [AW-1:0] LEN_RST = AW'(SZ);

  mode_e         modeQ;
  logic [AW-1:0] baseQ;
  logic [AW-1:0] lenQ;
  logic [AW-1:0] pcQ;
  mode_e         shMode;
  logic [AW-1:0] shBase;
  logic [AW-1:0] shLen;
  logic          swapping;

  always_comb begin
    swapping  = ctl.memWrite || ctl.memRead;
    isUser    = (modeQ == MODE_USER);
    addrFault = memReq && (memVa > lenQ);
    accessOk  = memReq && !addrFault && !swapping;
    physAddr  = baseQ + memVa;
  end

  always_comb begin
    memAddr      = '0;
    memAddr[2:0] = {ctl.slot, ctl.field};
    memWe        = ctl.memWrite;
    memRe        = ctl.memRead;
    case (ctl.field)
      2'd0:    memWdata = AW'(modeQ);
      2'd1:    memWdata = baseQ;
      2'd2:    memWdata = lenQ;
      default: memWdata = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shMode <= MODE_SUP;
      shBase <= '0;
      shLen  <= '0;
    end else if (ctl.memRead) begin
      case (ctl.field)
        2'd0:    shMode <= mode_e'(memRdata[0]);
        2'd1:    shBase <= memRdata;
        2'd2:    shLen  <= memRdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ <= MODE_SUP;
      baseQ <= '0;
      lenQ  <= LEN_RST;
      pcQ   <= '0;
    end else if (ctl.commit) begin
      modeQ <= shMode;
      baseQ <= shBase;
      lenQ  <= shLen;
      pcQ   <= memRdata;
    end else if (ctl.pcAllow && pcWrEn) begin
      pcQ <= pcIn;
    end
  end

  always_comb begin
    pswMode = (modeQ == MODE_SUP);
    pswBase = baseQ;
    pswLen  = lenQ;
    pswPc   = pcQ;
  end

  // R5: the status word holds still for the whole swap
  assert_psw_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swapping |-> $stable({modeQ, baseQ, lenQ, pcQ}));

  // R4: save beats walk the slot-0 words in ascending order
  assert_save_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe && memAddr[1:0] != 2'd3) |=> (memWe && memAddr == $past(memAddr) + AW'(1)));

endmodule

// File: rtl/psw_trap_unit.sv
module psw_trap_unit
  import psw_pkg::*;
#(
  parameter int AW = 8,
  parameter int SZ = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trapReq,
  input  logic          retReq,
  input  logic          privOp,
  input  logic          pcWrEn,
  input  logic [AW-1:0] pcIn,
  input  logic          memReq,
  input  logic [AW-1:0] memVa,
  output logic [AW-1:0] physAddr,
  output logic          accessOk,
  output logic          privAccept,
  output logic          busy,
  output logic          pswMode,
  output logic [AW-1:0] pswBase,
  output logic [AW-1:0] pswLen,
  output logic [AW-1:0] pswPc,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] memWdata,
  output logic          memWe,
  output logic          memRe,
  input  logic [AW-1:0] memRdata
);

  swapCtl_t ctl;
  logic     isUser;
  logic     addrFault;

  psw_control i_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .trapReq    (trapReq),
    .retReq     (retReq),
    .privOp     (privOp),
    .isUser     (isUser),
    .addrFault  (addrFault),
    .ctl        (ctl),
    .busy       (busy),
    .privAccept (privAccept)
  );

  psw_datapath #(.AW(AW), .SZ(SZ)) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .pcWrEn    (pcWrEn),
    .pcIn      (pcIn),
    .memReq    (memReq),
    .memVa     (memVa),
    .memRdata  (memRdata),
    .isUser    (isUser),
    .addrFault (addrFault),
    .accessOk  (accessOk),
    .physAddr  (physAddr),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memWe     (memWe),
    .memRe     (memRe),
    .pswMode   (pswMode),
    .pswBase   (pswBase),
    .pswLen    (pswLen),
    .pswPc     (pswPc)
  );

  // R3: an out-of-segment access while idle leads to a swap next cycle
  assert_fault_traps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memVa > pswLen && !busy) |=> busy);

  // R10: no translated access is granted during a swap
  assert_no_access_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accessOk);

endmodule

// File: tb/test_psw_trap_unit.sv
module test_psw_trap_unit;
  localparam int AW = 8;
  localparam int SZ = 200;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trapReq, retReq, privOp, pcWrEn, memReq;
  logic [AW-1:0] pcIn, memVa;
  logic [AW-1:0] physAddr, pswBase, pswLen, pswPc, memAddr, memWdata, memRdata;
  logic          accessOk, privAccept, busy, pswMode, memWe, memRe;
  logic [AW-1:0] mem [0:7];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  psw_trap_unit #(.AW(AW), .SZ(SZ)) i_psw_trap_unit (
    .clk(clk), .rst_n(rst_n), .trapReq(trapReq), .retReq(retReq), .privOp(privOp),
    .pcWrEn(pcWrEn), .pcIn(pcIn), .memReq(memReq), .memVa(memVa),
    .physAddr(physAddr), .accessOk(accessOk), .privAccept(privAccept), .busy(busy),
    .pswMode(pswMode), .pswBase(pswBase), .pswLen(pswLen), .pswPc(pswPc),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr[2:0]];
  always @(posedge clk) if (memWe) mem[memAddr[2:0]] <= memWdata;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // R2: every in-segment address is granted and offset by the base
  task automatic sweep(input int b, input int l);
    for (int va = 0; va <= l; va++) begin
      memVa = AW'(va); memReq = 1'b1;
      #1;
      chk("R2 accessOk", int'(accessOk), 1);
      chk("R2 physAddr", int'(physAddr), (b + va) % 256);
    end
    memReq = 1'b0;
  endtask

  // A trigger is already driven; walk the swap beats and check each one
  task automatic runSeq(input string req, input bit isTrap, input bit inject,
                        input int sm, input int sb, input int sl, input int sp);
    int n = isTrap ? 8 : 4;
    int sv[4];
    int nw[4];
    sv[0] = sm; sv[1] = sb; sv[2] = sl; sv[3] = sp;
    for (int k = 0; k < 4; k++) nw[k] = int'(mem[(isTrap ? 4 : 0) + k]);
    step;
    trapReq = 1'b0; retReq = 1'b0; privOp = 1'b0; memReq = 1'b0;
    for (int i = 0; i < n; i++) begin
      pcWrEn = (i == 0); pcIn = 8'd99;
      trapReq = inject && (i == 6);
      #1;
      chk({req, " R10 busy"}, int'(busy), 1);
      chk({req, " R10 accessOk"}, int'(accessOk), 0);
      chk({req, " addr"}, int'(memAddr), i);
      if (isTrap && i < 4) begin
        chk({req, " R4 write"}, int'(memWe), 1);
        chk({req, " R4 wdata"}, int'(memWdata), sv[i]);
      end else begin
        chk({req, " read"}, int'(memRe), 1);
        chk({req, " no write"}, int'(memWe), 0);
      end
      step;
    end
    pcWrEn = 1'b0; trapReq = 1'b0;
    #1;
    chk({req, " R10 busy end"}, int'(busy), 0);
    chk({req, " R5 mode"}, int'(pswMode), nw[0] % 2);
    chk({req, " R5 base"}, int'(pswBase), nw[1]);
    chk({req, " R5 len"}, int'(pswLen), nw[2]);
    chk({req, " R5 pc"}, int'(pswPc), nw[3]);
  endtask

  task automatic setSlot1(input int m, input int b, input int l, input int p);
    mem[4] = AW'(m); mem[5] = AW'(b); mem[6] = AW'(l); mem[7] = AW'(p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    rst_n = 1'b0; trapReq = 0; retReq = 0; privOp = 0; pcWrEn = 0; memReq = 0;
    pcIn = '0; memVa = '0;
    for (int i = 0; i < 8; i++) mem[i] = '0;
    repeat (3) step;
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 mode", int'(pswMode), 1);
    chk("R1 base", int'(pswBase), 0);
    chk("R1 len", int'(pswLen), SZ);
    chk("R1 pc", int'(pswPc), 0);

    // R12 pc write while idle
    pcWrEn = 1'b1; pcIn = 8'd5;
    step;
    pcWrEn = 1'b0;
    #1 chk("R12 pc", int'(pswPc), 5);

    sweep(0, SZ);

    // R7 supervisor privileged op executes without a swap
    privOp = 1'b1;
    #1 chk("R7 privAccept sup", int'(privAccept), 1);
    step;
    privOp = 1'b0;
    #1 chk("R7 no swap", int'(busy), 0);

    // R4/R5 trap into a user segment
    setSlot1(0, 40, 100, 7);
    trapReq = 1'b1;
    runSeq("R4", 1'b1, 1'b0, 1, 0, SZ, 5);
    chk("R5 user", int'(pswMode), 0);

    sweep(40, 100);

    // R3 fault at length+1, handler in supervisor with a noisy mode word
    setSlot1(3, 0, SZ, 50);
    memVa = 8'd101; memReq = 1'b1;
    #1 chk("R3 accessOk", int'(accessOk), 0);
    runSeq("R3", 1'b1, 1'b0, 0, 40, 100, 7);
    chk("R11 mode from word 3", int'(pswMode), 1);

    // R6 return to the user segment
    retReq = 1'b1;
    runSeq("R6", 1'b0, 1'b0, 0, 0, 0, 0);

    // R7 user privileged op traps
    privOp = 1'b1;
    #1 chk("R7 privAccept user", int'(privAccept), 0);
    runSeq("R7", 1'b1, 1'b0, 0, 40, 100, 7);
    retReq = 1'b1;
    runSeq("R6 again", 1'b0, 1'b0, 0, 0, 0, 0);

    // R8 user return traps
    retReq = 1'b1;
    runSeq("R8", 1'b1, 1'b0, 0, 40, 100, 7);
    chk("R8 sup pc", int'(pswPc), 50);
    retReq = 1'b1;
    runSeq("R6 third", 1'b0, 1'b0, 0, 0, 0, 0);

    // R9 trap request during a swap; R11 mode word 2 means user
    setSlot1(2, 10, 20, 30);
    trapReq = 1'b1;
    runSeq("R9 first", 1'b1, 1'b1, 0, 40, 100, 7);
    chk("R11 mode from word 2", int'(pswMode), 0);
    runSeq("R9 held", 1'b1, 1'b0, 0, 10, 20, 30);
    chk("R9 second done len", int'(pswLen), 20);

    sweep(10, 20);
    finishRun();
  end

endmodule